// File: doc/BRIEF.md
# Sub-word Access Data Memory

A byte-organized synchronous data store for a processor datapath. One address input selects a starting byte. A two-bit access mode sets the width of both the read and the write. The mode can switch the store off, or move one byte, two bytes or four bytes. Writes take effect on the rising clock edge while the write enable is high. Reads are combinational from the present address and mode.

Sub-word writes change only the addressed bytes. Sub-word reads are zero-extended to 32 bits. The array is indexed by the low-order address bits only, so any wider address folds back onto it. Multi-byte transfers that run past the last byte wrap around to byte 0, and no alignment is required.

A synchronous active-low reset loads every byte with a fill value, 0x81 by default. A build parameter can remove the mode pin's influence. The store then always performs word access.

Top module: `subword_dmem`

## Requirements
- R1: The mode input selects the transfer width: 2'b00 = off, 2'b01 = one byte, 2'b10 = two bytes, 2'b11 = four bytes.
- R2: With mode 2'b00, `rdata` is 0 and the array is unchanged, even while `we` is high.
- R3: Byte and half-word reads are zero-extended: `rdata[31:8]` is 0 in byte mode and `rdata[31:16]` is 0 in half-word mode.
- R4: Byte and half-word writes store only `wdata[7:0]` or `wdata[15:0]`; the upper write bits and all bytes outside the access are left untouched.
- R5: Byte order is little-endian: the byte at `addr` carries bits 7:0, and `addr+1`, `addr+2` and `addr+3` carry the next-higher bytes.
- R6: Only the low log2(BYTES) address bits select the location, so `addr` and `addr + k*BYTES` reach the same byte.
- R7: While `rst_n` is low at a rising edge, every byte is loaded with FILL (default 8'h81); a word read after reset returns 32'h81818181.
- R8: Multi-byte accesses wrap modulo BYTES past the last byte and need no alignment.
- R9: Reset wins over a write in the same cycle; the write is lost.
- R10: With MODE_PORT_EN = 0, the mode pin is ignored and every access is a four-byte access.
- R11: A write commits at the rising edge while `we` is high, and a read of that location returns the new data in the cycle right after that edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset that fills the array |
| addr | input | ADDR_W | Byte address of the access; only the low bits are used |
| mode | input | 2 | Access width: off, byte, half-word, word |
| we | input | 1 | Write enable, active high |
| wdata | input | 32 | Write data, aligned to bit 0 |
| rdata | output | 32 | Zero-extended read data |

## Verification
Reset and a write can meet at the same rising edge. The bench provokes this by driving `rst_n` low while `we` is high in word mode, with a distinctive value at a fresh address. After releasing reset it reads that address back and expects the fill pattern, not the written data (R9). A second collision is a write that crosses the top of the array. It is judged by reading from both ends of the array to check that the bytes wrapped to the start and did not vanish (R8).

// File: rtl/subword_dmem_pkg.sv
// Shared types for the sub-word data memory.
// Assumes a 32-bit data path split into four 8-bit lanes.
package subword_dmem_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        ACC_OFF  = 2'b00,
        ACC_BYTE = 2'b01,
        ACC_HALF = 2'b10,
        ACC_WORD = 2'b11
    } acc_mode_e;
endpackage

// File: rtl/dmem_lane_dec.sv
// Turns the access mode into a lane mask for reads and a lane mask for writes.
// Assumes lane 0 is always the addressed byte; higher lanes follow it upward.
module dmem_lane_dec
    import subword_dmem_pkg::*;
(
    input  acc_mode_e        mode,
    input  logic             we,
    output logic [LANES-1:0] rd_mask,
    output logic [LANES-1:0] wr_lanes
);
    // Width decode: one bit per byte lane that takes part in the access.
    always_comb begin
        unique case (mode)
            ACC_OFF:  rd_mask = '0;
            ACC_BYTE: rd_mask = LANES'(1);
            ACC_HALF: rd_mask = LANES'(3);
            default:  rd_mask = '1;
        endcase
    end

    // Write lanes follow the read mask only while the enable is high.
    always_comb wr_lanes = we ? rd_mask : '0;
endmodule

// File: rtl/dmem_array.sv
// Byte-wide storage with per-lane writes and a synchronous fill on reset.
// Assumes BYTES is a power of two, so lane addresses wrap by plain overflow.
module dmem_array
    import subword_dmem_pkg::*;
#(
    parameter int          BYTES = 4096,
    parameter logic [7:0]  FILL  = 8'h81,
    localparam int         AW    = $clog2(BYTES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 base,
    input  logic [LANES-1:0]              wr_lanes,
    input  logic [DATA_W-1:0]             wdata,
    output logic [LANES-1:0][BYTE_W-1:0]  rd_bytes
);
    logic [BYTE_W-1:0] cells [BYTES];
    logic [AW-1:0]     lane_addr [LANES];

    // Per-lane address and read tap; AW-bit addition gives the wrap.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_addr[k] = base + AW'(k);
        assign rd_bytes[k]  = cells[lane_addr[k]];
    end

    // Storage update: reset fill takes priority over any lane write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) cells[i] <= FILL;
        end else begin
            for (int k = 0; k < LANES; k++)
                if (wr_lanes[k]) cells[lane_addr[k]] <= wdata[k*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/dmem_rd_fmt.sv
// Assembles read data from the lane taps, zeroing lanes outside the access.
// Assumes the mask is contiguous from lane 0, which gives zero-extension.
module dmem_rd_fmt
    import subword_dmem_pkg::*;
(
    input  logic [LANES-1:0]             rd_mask,
    input  logic [LANES-1:0][BYTE_W-1:0] rd_bytes,
    output logic [DATA_W-1:0]            rdata
);
    // Lane gating: each byte of the result is its tap or zero.
    for (genvar k = 0; k < LANES; k++) begin : g_fmt
        assign rdata[k*BYTE_W +: BYTE_W] = rd_mask[k] ? rd_bytes[k] : '0;
    end
endmodule

// File: rtl/subword_dmem.sv
// Sub-word data memory top: folds the address, decodes the mode, stores
// and formats. Assumes ADDR_W >= log2(BYTES) and that BYTES is a power of two.
module subword_dmem
    import subword_dmem_pkg::*;
#(
    parameter int         BYTES        = 4096,
    parameter int         ADDR_W       = 32,
    parameter logic [7:0] FILL         = 8'h81,
    parameter bit         MODE_PORT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        mode,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int AW = $clog2(BYTES);

    acc_mode_e                   mode_eff;
    logic [LANES-1:0]            rd_mask;
    logic [LANES-1:0]            wr_lanes;
    logic [LANES-1:0][BYTE_W-1:0] rd_bytes;
    logic [AW-1:0]               base;

    // Address folding: upper bits do not reach the array.
    assign base = addr[AW-1:0];
    if (ADDR_W > AW) begin : g_fold
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:AW];
    end

    // Mode source: the pin, or fixed word access when the pin is disabled.
    if (MODE_PORT_EN) begin : g_mode_pin
        assign mode_eff = acc_mode_e'(mode);
    end else begin : g_mode_word
        logic unused_mode;
        assign unused_mode = ^mode;
        assign mode_eff    = ACC_WORD;
    end

    dmem_lane_dec u_dec (
        .mode     (mode_eff),
        .we       (we),
        .rd_mask  (rd_mask),
        .wr_lanes (wr_lanes)
    );

    dmem_array #(.BYTES(BYTES), .FILL(FILL)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (base),
        .wr_lanes (wr_lanes),
        .wdata    (wdata),
        .rd_bytes (rd_bytes)
    );

    dmem_rd_fmt u_fmt (
        .rd_mask  (rd_mask),
        .rd_bytes (rd_bytes),
        .rdata    (rdata)
    );
endmodule

// File: rtl/subword_dmem_chk.sv
// Property checker for the sub-word data memory, bound to every instance.
// Assumes it sees the effective mode, not the raw pin.
module subword_dmem_chk
    import subword_dmem_pkg::*;
#(
    parameter int         ADDR_W = 32,
    parameter logic [7:0] FILL   = 8'h81
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input acc_mode_e         mode,
    input logic              we,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata
);
    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ACC_OFF |-> rdata == 32'h0);

    // R3
    byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ACC_BYTE |-> rdata[31:8] == 24'h0);

    // R3
    half_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ACC_HALF |-> rdata[31:16] == 16'h0);

    // R11
    word_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mode == ACC_WORD) ##1 ($stable(addr) && mode == ACC_WORD)
        |-> rdata == $past(wdata));

    // R4
    byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mode == ACC_BYTE) ##1 ($stable(addr) && mode == ACC_WORD)
        |-> rdata[7:0] == $past(wdata[7:0]));

    // R7
    fill_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && mode == ACC_WORD) |-> rdata == {4{FILL}});
endmodule

bind subword_dmem subword_dmem_chk #(.ADDR_W(ADDR_W), .FILL(FILL)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .mode  (mode_eff),
    .we    (we),
    .wdata (wdata),
    .rdata (rdata)
);

// File: tb/subword_dmem_test.sv
// Directed bench for the sub-word data memory; each task checks its own results.
module subword_dmem_test;
    localparam int BYTES = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  mode = 2'b11;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] rdata_def;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    subword_dmem #(.BYTES(BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mode(mode),
        .we(we), .wdata(wdata), .rdata(rdata)
    );

    subword_dmem #(.BYTES(BYTES), .MODE_PORT_EN(1'b0)) u_def (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mode(2'b00),
        .we(we), .wdata(wdata), .rdata(rdata_def)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [1:0] m, input logic [31:0] d);
        @(negedge clk);
        addr = a; mode = m; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] m, output logic [31:0] q);
        @(negedge clk);
        addr = a; mode = m;
        #1 q = rdata;
    endtask

    task automatic test_reset();
        logic [31:0] q;
        rd(32'h0, 2'b11, q);   check("R7 word fill", q, 32'h81818181);
        rd(32'h5, 2'b01, q);   check("R3 byte fill zero-ext", q, 32'h00000081);
    endtask

    task automatic test_word_endian();
        logic [31:0] q;
        wr(32'h100, 2'b11, 32'h11223344);
        rd(32'h100, 2'b11, q); check("R11 word readback", q, 32'h11223344);
        rd(32'h100, 2'b01, q); check("R5 low byte", q, 32'h00000044);
        rd(32'h103, 2'b01, q); check("R5 high byte", q, 32'h00000011);
    endtask

    task automatic test_subword_write();
        logic [31:0] q;
        wr(32'h101, 2'b01, 32'hFFFFFFAA);
        rd(32'h100, 2'b11, q); check("R4 byte merge", q, 32'h1122AA44);
        wr(32'h102, 2'b10, 32'hDEADBEEF);
        rd(32'h100, 2'b11, q); check("R4 half merge", q, 32'hBEEFAA44);
        rd(32'h102, 2'b10, q); check("R3 half zero-ext", q, 32'h0000BEEF);
        rd(32'h101, 2'b01, q); check("R1 byte width", q, 32'h000000AA);
    endtask

    task automatic test_off();
        logic [31:0] q;
        @(negedge clk);
        addr = 32'h100; mode = 2'b00; wdata = 32'h0; we = 1'b1;
        #1 check("R2 off read zero", rdata, 32'h0);
        @(negedge clk);
        we = 1'b0;
        rd(32'h100, 2'b11, q); check("R2 off write ignored", q, 32'hBEEFAA44);
    endtask

    task automatic test_alias();
        logic [31:0] q;
        wr(32'h1200, 2'b11, 32'hCAFEF00D);
        rd(32'h200, 2'b11, q);      check("R6 alias low", q, 32'hCAFEF00D);
        rd(32'hABCD1200, 2'b11, q); check("R6 alias high", q, 32'hCAFEF00D);
    endtask

    task automatic test_wrap();
        logic [31:0] q;
        wr(32'hFFE, 2'b11, 32'h0A0B0C0D);
        rd(32'hFFE, 2'b11, q); check("R8 wrap read", q, 32'h0A0B0C0D);
        rd(32'h000, 2'b11, q); check("R8 wrapped bytes", q, 32'h81810A0B);
        wr(32'h401, 2'b11, 32'h55667788);
        rd(32'h401, 2'b11, q); check("R8 unaligned word", q, 32'h55667788);
        rd(32'h400, 2'b01, q); check("R8 unaligned neighbour", q, 32'h00000081);
    endtask

    task automatic test_default_mode();
        logic [31:0] q;
        wr(32'h500, 2'b11, 32'h9ABCDEF0);
        rd(32'h500, 2'b01, q);
        check("R10 pin honoured", q, 32'h000000F0);
        check("R10 pin ignored", rdata_def, 32'h9ABCDEF0);
    endtask

    task automatic test_reset_prio();
        logic [31:0] q;
        @(negedge clk);
        rst_n = 1'b0; addr = 32'h300; mode = 2'b11; wdata = 32'h12345678; we = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; we = 1'b0;
        rd(32'h300, 2'b11, q); check("R9 reset beats write", q, 32'h81818181);
        rd(32'h100, 2'b11, q); check("R7 refill", q, 32'h81818181);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_word_endian();
        test_subword_write();
        test_off();
        test_alias();
        test_wrap();
        test_default_mode();
        test_reset_prio();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule